// File: doc/BRIEF.md
# Polarity-Aware Interrupt Status Block

This block gathers thirty-two level-sensitive interrupt sources from neighbouring logic and presents them to software through four 32-bit registers on a simple request/response register bus. Each source is first compared against a per-bit polarity setting. The effective level (source XOR polarity) sets a sticky status bit that software clears by writing ones to it. The status is gated by a per-bit enable mask, and the OR of the enabled bits is driven upward as a single registered interrupt line.

Bit 11 of every register belongs to the host-controller interrupt, which enters on its own port. The other thirty-one bits come from a general source vector. Software can also read the unlatched source vector to see the live levels next to the latched status. Register data is word-wide, with the most significant byte on bus bits 31:24. An access that does not enable all four byte lanes is treated like an access to an unmapped offset.

Top module: `irq_stat_regs`

## Requirements
- R1: After the synchronous reset, status, mask and polarity are all zero, `irq_out` is low and `rd_valid` is low.
- R2: The registers sit at byte offsets 0x50 (status), 0x54 (mask), 0x58 (polarity) and 0x5C (raw sources). A read request is answered on the next clock with `rd_valid` high for one cycle and the data on `rd_data`.
- R3: A status bit becomes set on the clock after its source level XOR its polarity bit equals one. It then stays set after the level goes away.
- R4: A write to the status offset clears each bit written as one and leaves each bit written as zero unchanged. If a bit's effective level is one in the same cycle as its clear, the bit stays set.
- R5: Mask and polarity each hold all 32 written bits and read back exactly what was written.
- R6: Reading the raw offset returns the source vector present in the request cycle. A write to the raw offset changes no register.
- R7: `irq_out` is the OR of (status AND mask), registered. It follows status and mask one clock after they change.
- R8: A read of any other offset, including an unaligned one, returns 0xFFFFFFFF. A write to such an offset changes no register.
- R9: An access whose byte enables are not all ones has no effect when it is a write. When it is a read, it returns 0xFFFFFFFF.
- R10: Bit 11 of status and raw is driven by `host_irq`. Bit 11 of `aux_irq` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_irq | input | 1 | Host-controller interrupt level, placed at bit 11 |
| aux_irq | input | 32 | Other interrupt levels; bit 11 unused |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset |
| req_be | input | 4 | Byte-lane enables; only 4'hF is accepted |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Read response data |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
A software clear of a status bit can land in the same cycle as that bit's effective level being asserted again. The bench provokes this by holding a source high across the write-one-to-clear cycle, and also by mixing random source pulses with random status writes. The outcome is judged against a behavioural model in which setting wins over clearing. That model is compared with `irq_out` and the read data on every clock, and a directed read then confirms that the bit survived.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int unsigned OFF_STAT = 32'h50;
  localparam int unsigned OFF_MASK = 32'h54;
  localparam int unsigned OFF_POL  = 32'h58;
  localparam int unsigned OFF_RAW  = 32'h5C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_MASK,
    SEL_POL,
    SEL_RAW
  } reg_sel_e;
endpackage

// File: rtl/irq_src_merge.sv
module irq_src_merge #(
  parameter int unsigned W        = 32,
  parameter int unsigned HOST_BIT = 11
) (
  input  logic         host_irq,
  input  logic [W-1:0] aux_irq,
  output logic [W-1:0] raw
);
  logic unused_host_slot;
  assign unused_host_slot = aux_irq[HOST_BIT];

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == HOST_BIT) begin : g_host
      assign raw[i] = host_irq;
    end else begin : g_aux
      assign raw[i] = aux_irq[i];
    end
  end
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BE_W   = 4
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  output reg_sel_e          sel,
  output logic              wr_stat,
  output logic              wr_mask,
  output logic              wr_pol,
  output logic              rd_en
);
  logic full_word;
  assign full_word = &req_be;

  always_comb begin
    sel = SEL_NONE;
    if (full_word) begin
      if (req_addr == ADDR_W'(OFF_STAT))      sel = SEL_STAT;
      else if (req_addr == ADDR_W'(OFF_MASK)) sel = SEL_MASK;
      else if (req_addr == ADDR_W'(OFF_POL))  sel = SEL_POL;
      else if (req_addr == ADDR_W'(OFF_RAW))  sel = SEL_RAW;
    end
  end

  assign wr_stat = req_valid && req_write && (sel == SEL_STAT);
  assign wr_mask = req_valid && req_write && (sel == SEL_MASK);
  assign wr_pol  = req_valid && req_write && (sel == SEL_POL);
  assign rd_en   = req_valid && !req_write;
endmodule

// File: rtl/irq_status_core.sv
module irq_status_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  input  logic         wr_stat,
  input  logic         wr_mask,
  input  logic         wr_pol,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] pol_q,
  output logic         irq_out
);
  logic [W-1:0] hit;
  logic [W-1:0] clr;

  assign hit = raw ^ pol_q;
  assign clr = wr_stat ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      pol_q    <= '0;
      irq_out  <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr) | hit;
      if (wr_mask) mask_q <= wdata;
      if (wr_pol)  pol_q  <= wdata;
      irq_out  <= |(status_q & mask_q);
    end
  end

  // R1
  cfg_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '0 && pol_q == '0 && status_q == '0 && !irq_out));

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((status_q & $past(hit)) == $past(hit)));

  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_stat)) |-> ((status_q & $past(status_q)) == $past(status_q)));

  // R4
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_stat)) |-> ((status_q & $past(wdata & ~hit)) == '0));

  // R7
  summary_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_out == (|($past(status_q) & $past(mask_q)))));
endmodule

// File: rtl/irq_stat_regs.sv
module irq_stat_regs
  import irq_stat_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned HOST_BIT = 11,
  localparam int unsigned BE_W    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_irq,
  input  logic [DATA_W-1:0] aux_irq,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_out
);
  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] status_q, mask_q, pol_q;
  reg_sel_e          sel;
  logic              wr_stat, wr_mask, wr_pol, rd_en;

  irq_src_merge #(.W(DATA_W), .HOST_BIT(HOST_BIT)) u_merge (
    .host_irq (host_irq),
    .aux_irq  (aux_irq),
    .raw      (raw)
  );

  irq_reg_decode #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_decode (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .sel       (sel),
    .wr_stat   (wr_stat),
    .wr_mask   (wr_mask),
    .wr_pol    (wr_pol),
    .rd_en     (rd_en)
  );

  irq_status_core #(.W(DATA_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .raw      (raw),
    .wr_stat  (wr_stat),
    .wr_mask  (wr_mask),
    .wr_pol   (wr_pol),
    .wdata    (req_wdata),
    .status_q (status_q),
    .mask_q   (mask_q),
    .pol_q    (pol_q),
    .irq_out  (irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        case (sel)
          SEL_STAT: rd_data <= status_q;
          SEL_MASK: rd_data <= mask_q;
          SEL_POL:  rd_data <= pol_q;
          SEL_RAW:  rd_data <= raw;
          default:  rd_data <= '1;
        endcase
      end
    end
  end

  // R2
  rd_response_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rd_valid == $past(rd_en)));

  // R8
  unmapped_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && $past(sel == SEL_NONE)) |-> (rd_data == '1));

  // R10
  host_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_en) && $past(sel == SEL_RAW)) |-> (rd_data[HOST_BIT] == $past(host_irq)));
endmodule

// File: tb/irq_stat_regs_bench.sv
module irq_stat_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_irq = 1'b0;
  logic [31:0] aux_irq = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [3:0]  req_be = 4'hF;
  logic [31:0] req_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_stat_regs u_irq_stat_regs (
    .clk(clk), .rst(rst), .host_irq(host_irq), .aux_irq(aux_irq),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq_out(irq_out)
  );

  // behavioural reference model
  logic [31:0] m_stat, m_mask, m_pol, m_rd;
  logic        m_irq, m_rv;

  function automatic logic [31:0] src_vec(logic [31:0] a, logic h);
    logic [31:0] v = a;
    v[11] = h;
    return v;
  endfunction

  always @(posedge clk) begin
    logic [31:0] eff, clr, rdv;
    bit ok, hitreg;
    if (rst) begin
      m_stat <= '0; m_mask <= '0; m_pol <= '0;
      m_irq <= 1'b0; m_rv <= 1'b0; m_rd <= '0;
    end else begin
      eff = src_vec(aux_irq, host_irq) ^ m_pol;
      ok  = (req_be == 4'hF);
      clr = (req_valid && req_write && ok && req_addr == 12'h050) ? req_wdata : 32'h0;
      m_irq  <= (m_stat & m_mask) != 0;
      m_stat <= (m_stat & ~clr) | eff;
      if (req_valid && req_write && ok && req_addr == 12'h054) m_mask <= req_wdata;
      if (req_valid && req_write && ok && req_addr == 12'h058) m_pol  <= req_wdata;
      m_rv <= req_valid && !req_write;
      if (req_valid && !req_write) begin
        hitreg = ok;
        rdv = 32'hFFFF_FFFF;
        if (hitreg) begin
          case (req_addr)
            12'h050: rdv = m_stat;
            12'h054: rdv = m_mask;
            12'h058: rdv = m_pol;
            12'h05C: rdv = src_vec(aux_irq, host_irq);
            default: rdv = 32'hFFFF_FFFF;
          endcase
        end
        m_rd <= rdv;
      end
    end
  end

  task automatic check(bit cond, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(irq_out == m_irq, "R7 irq_out vs model", {31'b0, irq_out}, {31'b0, m_irq});
      check(rd_valid == m_rv, "R2 rd_valid vs model", {31'b0, rd_valid}, {31'b0, m_rv});
      if (rd_valid)
        check(rd_data == m_rd, "R2 rd_data vs model", rd_data, m_rd);
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_be = 4'hF;
  endtask

  task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string tag, logic [3:0] be = 4'hF);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
    @(negedge clk);
    check(rd_valid && rd_data == exp, tag, rd_data, exp);
    req_valid = 1'b0; req_be = 4'hF;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(!irq_out && !rd_valid, "R1 outputs after reset", {30'b0, irq_out, rd_valid}, 32'h0);
    rd_chk(12'h050, 32'h0, "R1 status reset");
    rd_chk(12'h054, 32'h0, "R1 mask reset");
    rd_chk(12'h058, 32'h0, "R1 polarity reset");
    // R5 polarity and R3 polarity-driven capture
    wr(12'h058, 32'hA5A5_0F0F);
    rd_chk(12'h058, 32'hA5A5_0F0F, "R5 polarity readback");
    rd_chk(12'h050, 32'hA5A5_0F0F, "R3 inverted polarity sets status");
    wr(12'h058, 32'h0);
    wr(12'h050, 32'hFFFF_FFFF);
    rd_chk(12'h050, 32'h0, "R4 clear all");
    // R3 sticky capture of a pulse
    @(negedge clk); aux_irq = 32'h13;
    @(negedge clk); aux_irq = 32'h0;
    rd_chk(12'h050, 32'h13, "R3 pulse latched");
    // R4 zeros unchanged
    wr(12'h050, 32'h1);
    rd_chk(12'h050, 32'h12, "R4 partial clear");
    // R4 set wins over clear
    @(negedge clk); aux_irq = 32'h10;
    wr(12'h050, 32'h10);
    aux_irq = 32'h0;
    rd_chk(12'h050, 32'h12, "R4 set wins in same cycle");
    wr(12'h050, 32'h12);
    rd_chk(12'h050, 32'h0, "R4 cleared after level drops");
    // R7 summary latency and masking
    wr(12'h054, 32'h4);
    rd_chk(12'h054, 32'h4, "R5 mask readback");
    @(negedge clk); aux_irq = 32'h4;
    @(negedge clk); aux_irq = 32'h0;
    check(!irq_out, "R7 irq not yet raised", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check(irq_out, "R7 irq raised one clock after status", {31'b0, irq_out}, 32'h1);
    wr(12'h054, 32'h0);
    @(negedge clk);
    check(!irq_out, "R7 irq dropped by mask", {31'b0, irq_out}, 32'h0);
    wr(12'h050, 32'h4);
    // R10 host bit
    @(negedge clk); host_irq = 1'b1;
    @(negedge clk); host_irq = 1'b0;
    rd_chk(12'h050, 32'h800, "R10 host_irq sets bit 11");
    wr(12'h050, 32'h800);
    @(negedge clk); aux_irq = 32'h800;
    @(negedge clk); aux_irq = 32'h0;
    rd_chk(12'h050, 32'h0, "R10 aux bit 11 ignored");
    // R6 raw read
    @(negedge clk); aux_irq = 32'h8000_0800;
    rd_chk(12'h05C, 32'h8000_0000, "R6 raw read, R10 slot");
    host_irq = 1'b1;
    rd_chk(12'h05C, 32'h8000_0800, "R6 raw read with host");
    host_irq = 1'b0; aux_irq = 32'h0;
    wr(12'h050, 32'hFFFF_FFFF);
    // R6 write ignored
    wr(12'h054, 32'h00F0_0001);
    wr(12'h05C, 32'hFFFF_FFFF);
    rd_chk(12'h054, 32'h00F0_0001, "R6 raw write leaves mask");
    rd_chk(12'h058, 32'h0, "R6 raw write leaves polarity");
    rd_chk(12'h050, 32'h0, "R6 raw write leaves status");
    // R8 unmapped
    rd_chk(12'h060, 32'hFFFF_FFFF, "R8 unmapped read");
    rd_chk(12'h04C, 32'hFFFF_FFFF, "R8 unmapped read below");
    rd_chk(12'h052, 32'hFFFF_FFFF, "R8 unaligned read");
    wr(12'h060, 32'h0);
    rd_chk(12'h054, 32'h00F0_0001, "R8 unmapped write no effect");
    // R9 partial byte enables
    wr(12'h054, 32'h0, 4'h7);
    rd_chk(12'h054, 32'h00F0_0001, "R9 partial write ignored");
    rd_chk(12'h054, 32'hFFFF_FFFF, "R9 partial read all ones", 4'h1);
    // R2 random traffic compared on every clock
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      aux_irq   = ($urandom % 4 == 0) ? $urandom : 32'h0;
      host_irq  = ($urandom % 5 == 0);
      req_valid = ($urandom % 2 == 0);
      req_write = $urandom % 2;
      req_addr  = 12'h050 + 12'(4 * ($urandom % 5));
      req_be    = ($urandom % 8 == 0) ? 4'h3 : 4'hF;
      req_wdata = $urandom;
    end
    @(negedge clk);
    req_valid = 1'b0; aux_irq = '0; host_irq = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule